// File: doc/BRIEF.md
# Packet Buffer Allocator and Queues

This block keeps track of four packet buffers in a shared buffer memory. It owns a bitmap that says which buffers are in use. It also owns three short queues of buffer numbers. The receive queue holds buffers that carry received frames. The transmit queue holds buffers waiting to be sent. The completion queue holds buffers whose transmission has finished and which the host has not yet reclaimed.

The host drives the block with one-byte command writes. The operation code sits in bits 7:5 of the byte. The receive path asks for a buffer once per incoming frame. The transmit path is modelled only as a start pulse from this block and a completion pulse back to it.

The block presents to the host:
- the result of the last transmit allocation;
- the head of the receive queue and the head of the completion queue;
- the number of buffers in use and the fixed buffer total;
- level signals for an interrupt unit.

The buffer memory, frame layout and the wire side are handled elsewhere.

Top module: `pkb_mmu`

## Requirements
- R1: A transmit allocation (opcode 1 in bits 7:5 of `cmd_byte`) takes the lowest-numbered free buffer and marks it used. It places the buffer number, zero-extended to 8 bits, on `alloc_result` and sets `alloc_irq`. The result is visible in the cycle after the command.
- R2: A transmit allocation first sets `alloc_result` to 0x80 and clears `alloc_irq`. If all buffers are in use, it leaves them that way: `alloc_result` reads 0x80 and `alloc_irq` reads 0.
- R3: A buffer can be released by opcode 5 (the buffer named by `cur_pkt`), by opcode 4, or by an automatic release after transmit. If `alloc_result` is 0x80 at that point, the transmit allocation is retried in the same cycle and, on success, `alloc_irq` is set.
- R4: Opcode 2 does all of the following:
  - empties the bitmap and all three queues;
  - aborts any transmission in flight;
  - sets `alloc_result` to 0;
  - refuses a receive request made in the same cycle.
- R5: `rx_head` and `done_head` show the buffer number at the head of their queue, or 0x80 when that queue is empty. `rx_pending` and `done_pending` are high when the matching queue is non-empty.
- R6: With the receiver enabled and not in soft reset, `rx_req` is accepted only if, after this cycle's releases and pops, at least one buffer is free and the receive queue holds fewer than 4 entries. On acceptance:
  - `rx_accept` pulses in the same cycle and `rx_buf` names the lowest free buffer;
  - that buffer is marked used;
  - the buffer is appended to the receive queue.

  `rx_ready` is high when the receiver is disabled, or in soft reset, or when the registered bitmap is not full and the receive queue holds fewer than 4 entries.
- R7: `rx_req` has no effect while `rx_enable` is low or `rx_soft_rst` is high.
- R8: Opcode 3 removes the head of the receive queue and keeps its buffer allocated. Opcode 4 removes the head and also releases its buffer. Either opcode on an empty queue changes nothing.
- R9: Opcode 6 appends `cur_pkt` to the transmit queue. The append is ignored when the queue already holds 4 entries after this cycle's pop.
- R10: `tx_start` pulses only when all of these hold:
  - `tx_enable` is high;
  - the transmit queue is non-empty;
  - no transmission is in flight;
  - no flush command is given in that cycle.

  `tx_pkt` names the head, which is removed from the queue. Only one transmission is in flight at a time, and buffers go out in queue order.
- R11: A `tx_done` pulse while a transmission is in flight ends it. With `auto_release` high the buffer is released. Otherwise the buffer is appended to the completion queue, unless that queue is full. `done_ack` removes the completion queue head, and it does so before any append made in the same cycle.
- R12: Opcode 7 empties the transmit and completion queues and aborts any transmission in flight. It leaves the bitmap unchanged.
- R13: `alloc_count` equals the number of buffers in use. `total_count` always reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Host command; bits 7:5 hold the opcode |
| cur_pkt | input | 2 | Buffer number used by opcodes 5 and 6 |
| auto_release | input | 1 | Free buffers on transmit completion |
| rx_enable | input | 1 | Receiver enabled |
| rx_soft_rst | input | 1 | Receiver held in soft reset |
| rx_req | input | 1 | Receive path requests a buffer |
| tx_enable | input | 1 | Transmitter enabled |
| tx_done | input | 1 | Transmission complete pulse |
| done_ack | input | 1 | Remove the completion queue head |
| alloc_result | output | 8 | Transmit allocation result, 0x80 on failure |
| alloc_irq | output | 1 | Allocation success event level |
| rx_head | output | 8 | Receive queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| alloc_count | output | 3 | Buffers in use |
| total_count | output | 3 | Buffer total (4) |
| rx_ready | output | 1 | Receive request would be accepted |
| rx_accept | output | 1 | Receive request accepted this cycle |
| rx_buf | output | 2 | Buffer given to the accepted receive |
| rx_pending | output | 1 | Receive queue non-empty |
| done_pending | output | 1 | Completion queue non-empty |
| tx_start | output | 1 | Transmission start pulse |
| tx_pkt | output | 2 | Buffer to transmit (head of transmit queue) |
| txq_empty | output | 1 | Transmit queue empty |

## Verification
The bench runs a directed sequence first. It fills the bitmap through transmit allocation, which separates a correct lowest-free choice from the 0x80 failure path. It then frees one buffer while the failure is pending, which shows the automatic retry. It overfills the transmit queue with the transmitter disabled and then drains it by handshake, which exposes the four-entry limit and the queue order. Receive bursts with the receiver enabled, disabled and in soft reset separate real acceptance from the pass-through readiness. A long stretch of mixed random commands, requests and completions then lands releases, pops, flushes and allocations in the same cycle, where the fixed order of same-cycle actions matters.

// File: rtl/pkb_pkg.sv
package pkb_pkg;

  // Code returned when no buffer could be handed out, or when a queue is empty
  localparam logic [7:0] NO_BUF = 8'h80;

  // Host operations, decoded from bits 7:5 of the command byte
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_TX_ALLOC  = 3'd1,
    OP_MMU_RESET = 3'd2,
    OP_RX_POP    = 3'd3,
    OP_RX_FREE   = 3'd4,
    OP_PKT_FREE  = 3'd5,
    OP_TX_QUEUE  = 3'd6,
    OP_TX_FLUSH  = 3'd7
  } mmu_op_e;

endpackage

// File: rtl/pkb_queue.sv
// Small shift-style queue of buffer numbers. Per cycle, in this order:
// flush wins over everything; otherwise pop, then push.
// A push is dropped when the queue is still full after the pop.
module pkb_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    if (pop && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
      cnt_d = cnt_q - CW'(1);
    end
    if (push && cnt_d < FULL_C) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_d) slot_d[i] = din;
      end
      cnt_d = cnt_d + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  assign head  = slot_q[0];
  assign count = cnt_q;

endmodule

// File: rtl/pkb_tx_seq.sv
// Start/complete handshake for one transmission at a time.
module pkb_tx_seq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_enable,
  input  logic         q_nonempty,
  input  logic         flush,
  input  logic         tx_done,
  input  logic [W-1:0] q_head,
  output logic         start,
  output logic         done_ok,
  output logic [W-1:0] cur
);

  logic         busy_q;
  logic [W-1:0] cur_q;

  assign start   = tx_enable && q_nonempty && !busy_q && !flush;
  assign done_ok = tx_done && busy_q && !flush;
  assign cur     = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cur_q  <= q_head;
    end else if (done_ok) begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pkb_mmu.sv
// Packet buffer allocator with receive, transmit and completion queues.
// Same-cycle order: completion, then host command, then receive request.
module pkb_mmu #(
  parameter int  NUM_BUF = 4,
  localparam int ID_W    = $clog2(NUM_BUF),
  localparam int CNT_W   = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic [ID_W-1:0]  cur_pkt,
  input  logic             auto_release,
  input  logic             rx_enable,
  input  logic             rx_soft_rst,
  input  logic             rx_req,
  input  logic             tx_enable,
  input  logic             tx_done,
  input  logic             done_ack,
  output logic [7:0]       alloc_result,
  output logic             alloc_irq,
  output logic [7:0]       rx_head,
  output logic [7:0]       done_head,
  output logic [CNT_W-1:0] alloc_count,
  output logic [CNT_W-1:0] total_count,
  output logic             rx_ready,
  output logic             rx_accept,
  output logic [ID_W-1:0]  rx_buf,
  output logic             rx_pending,
  output logic             done_pending,
  output logic             tx_start,
  output logic [ID_W-1:0]  tx_pkt,
  output logic             txq_empty
);
  import pkb_pkg::*;

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(NUM_BUF);

  typedef struct packed {
    logic            ok;
    logic [ID_W-1:0] idx;
  } grab_t;

  typedef struct packed {
    logic [NUM_BUF-1:0] bm;
    logic [7:0]         ares;
    logic               irq;
  } alloc_st_t;

  // ---------------- arithmetic helpers ----------------
  function automatic grab_t first_free(input logic [NUM_BUF-1:0] m);
    grab_t g;
    g = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (!m[i]) begin
        g.ok  = 1'b1;
        g.idx = ID_W'(i);
      end
    end
    return g;
  endfunction

  function automatic logic [CNT_W-1:0] pop_count(input logic [NUM_BUF-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_BUF; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [7:0] as_byte(input logic [ID_W-1:0] idx);
    return {{(8-ID_W){1'b0}}, idx};
  endfunction

  function automatic alloc_st_t do_alloc(input alloc_st_t s);
    alloc_st_t r;
    grab_t     g;
    r = s;
    g = first_free(s.bm);
    if (g.ok) begin
      r.bm[g.idx] = 1'b1;
      r.ares      = as_byte(g.idx);
      r.irq       = 1'b1;
    end
    return r;
  endfunction

  function automatic alloc_st_t do_release(input alloc_st_t s,
                                           input logic [ID_W-1:0] idx);
    alloc_st_t r;
    r = s;
    r.bm[idx] = 1'b0;
    if (r.ares == NO_BUF) r = do_alloc(r);
    return r;
  endfunction

  // ---------------- state ----------------
  alloc_st_t st_q, st_d;

  // ---------------- command decode (named events) ----------------
  mmu_op_e          op;
  logic             unused_cmd_low;
  logic             mmu_reset_cmd, flush_tx, rx_pop_cmd, tx_queue_cmd;
  logic             done_ok;
  logic [ID_W-1:0]  done_pkt;

  assign op             = mmu_op_e'(cmd_byte[7:5]);
  assign unused_cmd_low = ^cmd_byte[4:0];
  assign mmu_reset_cmd  = cmd_valid && op == OP_MMU_RESET;
  assign flush_tx       = cmd_valid && (op == OP_MMU_RESET || op == OP_TX_FLUSH);
  assign rx_pop_cmd     = cmd_valid && (op == OP_RX_POP || op == OP_RX_FREE);
  assign tx_queue_cmd   = cmd_valid && op == OP_TX_QUEUE;

  // ---------------- queue wiring ----------------
  logic [ID_W-1:0]  rxq_head, txq_head, dq_head;
  logic [CNT_W-1:0] rxq_cnt, txq_cnt, dq_cnt;
  logic [CNT_W-1:0] rxq_cnt_after;
  logic             rx_take;
  logic [ID_W-1:0]  rx_idx;

  assign rxq_cnt_after = rxq_cnt - CNT_W'(rx_pop_cmd && rxq_cnt != '0);

  // ---------------- allocation chain ----------------
  always_comb begin
    grab_t g;
    st_d    = st_q;
    rx_take = 1'b0;
    rx_idx  = '0;
    g       = '0;

    // step 1: transmit completion with automatic release
    if (done_ok && auto_release) st_d = do_release(st_d, done_pkt);

    // step 2: host command
    if (cmd_valid) begin
      unique case (op)
        OP_TX_ALLOC: begin
          st_d.ares = NO_BUF;
          st_d.irq  = 1'b0;
          st_d      = do_alloc(st_d);
        end
        OP_MMU_RESET: begin
          st_d.bm   = '0;
          st_d.ares = '0;
        end
        OP_RX_FREE: if (rxq_cnt != '0) st_d = do_release(st_d, rxq_head);
        OP_PKT_FREE: st_d = do_release(st_d, cur_pkt);
        default: ;
      endcase
    end

    // step 3: receive request
    if (rx_req && rx_enable && !rx_soft_rst && !mmu_reset_cmd &&
        !(&st_d.bm) && rxq_cnt_after < FULL_C) begin
      g               = first_free(st_d.bm);
      rx_take         = 1'b1;
      rx_idx          = g.idx;
      st_d.bm[g.idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  // ---------------- queues ----------------
  pkb_queue #(.DEPTH(NUM_BUF), .W(ID_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(mmu_reset_cmd),
    .push(rx_take), .din(rx_idx), .pop(rx_pop_cmd),
    .head(rxq_head), .count(rxq_cnt)
  );

  pkb_queue #(.DEPTH(NUM_BUF), .W(ID_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .push(tx_queue_cmd), .din(cur_pkt), .pop(tx_start),
    .head(txq_head), .count(txq_cnt)
  );

  pkb_queue #(.DEPTH(NUM_BUF), .W(ID_W)) u_doneq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .push(done_ok && !auto_release), .din(done_pkt), .pop(done_ack),
    .head(dq_head), .count(dq_cnt)
  );

  pkb_tx_seq #(.W(ID_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
    .q_nonempty(txq_cnt != '0), .flush(flush_tx), .tx_done(tx_done),
    .q_head(txq_head), .start(tx_start), .done_ok(done_ok), .cur(done_pkt)
  );

  // ---------------- outputs ----------------
  assign alloc_result = st_q.ares;
  assign alloc_irq    = st_q.irq;
  assign alloc_count  = pop_count(st_q.bm);
  assign total_count  = FULL_C;
  assign rx_pending   = rxq_cnt != '0;
  assign done_pending = dq_cnt != '0;
  assign rx_head      = rx_pending   ? as_byte(rxq_head) : NO_BUF;
  assign done_head    = done_pending ? as_byte(dq_head)  : NO_BUF;
  assign rx_ready     = !rx_enable || rx_soft_rst ||
                        (!(&st_q.bm) && rxq_cnt < FULL_C);
  assign rx_accept    = rx_take;
  assign rx_buf       = rx_idx;
  assign tx_pkt       = txq_head;
  assign txq_empty    = txq_cnt == '0;

endmodule

// File: rtl/pkb_mmu_chk.sv
module pkb_mmu_chk #(
  parameter int  NUM_BUF = 4,
  localparam int CNT_W   = $clog2(NUM_BUF + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mmu_reset_cmd,
  input logic             tx_enable,
  input logic             tx_start,
  input logic             alloc_irq,
  input logic [7:0]       alloc_result,
  input logic             rx_pending,
  input logic             done_pending,
  input logic [7:0]       rx_head,
  input logic [7:0]       done_head,
  input logic [CNT_W-1:0] alloc_count,
  input logic             rx_accept,
  input logic             rx_enable,
  input logic             rx_soft_rst
);

  a_r2_irq_means_valid: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq |-> alloc_result != 8'h80);

  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_reset_cmd |=> (alloc_count == '0 && alloc_result == 8'h00 &&
                       !rx_pending && !done_pending));

  a_r5_rx_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pending |-> rx_head == 8'h80);

  a_r5_done_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pending |-> done_head == 8'h80);

  a_r7_accept_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> (rx_enable && !rx_soft_rst));

  a_r10_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !tx_start);

  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r13_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_count <= CNT_W'(NUM_BUF));

endmodule

bind pkb_mmu pkb_mmu_chk #(.NUM_BUF(NUM_BUF)) u_chk (.*);

// File: tb/pkb_mmu_bench.sv
module pkb_mmu_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 0;
  logic [7:0] cmd_byte = 0;
  logic [1:0] cur_pkt = 0;
  logic       auto_release = 0, rx_enable = 0, rx_soft_rst = 0, rx_req = 0;
  logic       tx_enable = 0, tx_done = 0, done_ack = 0;
  logic [7:0] alloc_result, rx_head, done_head;
  logic       alloc_irq, rx_ready, rx_accept, rx_pending, done_pending;
  logic       tx_start, txq_empty;
  logic [2:0] alloc_count, total_count;
  logic [1:0] rx_buf, tx_pkt;

  always #5 clk = ~clk;

  pkb_mmu u_pkb_mmu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cur_pkt(cur_pkt), .auto_release(auto_release), .rx_enable(rx_enable),
    .rx_soft_rst(rx_soft_rst), .rx_req(rx_req), .tx_enable(tx_enable),
    .tx_done(tx_done), .done_ack(done_ack), .alloc_result(alloc_result),
    .alloc_irq(alloc_irq), .rx_head(rx_head), .done_head(done_head),
    .alloc_count(alloc_count), .total_count(total_count), .rx_ready(rx_ready),
    .rx_accept(rx_accept), .rx_buf(rx_buf), .rx_pending(rx_pending),
    .done_pending(done_pending), .tx_start(tx_start), .tx_pkt(tx_pkt),
    .txq_empty(txq_empty)
  );

  int n_cmp = 0, n_bad = 0, n_starts = 0;
  bit finished = 0;

  // ---------------- behavioural reference ----------------
  int m_bm, m_ar, m_cur;
  bit m_irq, m_busy;
  int m_rx[$], m_tx[$], m_dn[$];

  task automatic chk(string tag, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  function automatic int ones(int v);
    int c = 0;
    for (int i = 0; i < 4; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int lowest_free(int v);
    for (int i = 0; i < 4; i++) if (!v[i]) return i;
    return -1;
  endfunction

  task automatic m_try_tx();
    int f = lowest_free(m_bm);
    if (f >= 0) begin
      m_bm  = m_bm | (1 << f);
      m_ar  = f;
      m_irq = 1;
    end
  endtask

  task automatic m_release(int idx);
    m_bm = m_bm & ~(1 << idx);
    if (m_ar == 128) m_try_tx();
  endtask

  task automatic m_reset();
    m_bm = 0; m_ar = 0; m_cur = 0; m_irq = 0; m_busy = 0;
    m_rx.delete(); m_tx.delete(); m_dn.delete();
  endtask

  task automatic compare_and_step();
    int  op = cmd_byte[7:5];
    bit  cv = cmd_valid;
    bit  fl_all = cv && op == 2;
    bit  fl_tx = cv && (op == 2 || op == 7);
    bit  e_start, done_ok, e_acc;
    int  e_pkt = 0, e_buf = 0;
    // registered outputs against current reference state
    chk("R1", "alloc_result", alloc_result, m_ar);
    chk("R2", "alloc_irq", alloc_irq, m_irq);
    chk("R5", "rx_head", rx_head, m_rx.size() ? m_rx[0] : 128);
    chk("R11", "done_head", done_head, m_dn.size() ? m_dn[0] : 128);
    chk("R5", "rx_pending", rx_pending, m_rx.size() != 0);
    chk("R11", "done_pending", done_pending, m_dn.size() != 0);
    chk("R13", "alloc_count", alloc_count, ones(m_bm));
    chk("R13", "total_count", total_count, 4);
    chk("R9", "txq_empty", txq_empty, m_tx.size() == 0);
    chk("R6", "rx_ready", rx_ready,
        !rx_enable || rx_soft_rst || (m_bm != 15 && m_rx.size() < 4));
    // reaction to this cycle's inputs
    e_start = tx_enable && m_tx.size() > 0 && !m_busy && !fl_tx;
    if (e_start) e_pkt = m_tx[0];
    done_ok = tx_done && m_busy && !fl_tx;
    if (done_ok && auto_release) m_release(m_cur);
    if (cv) begin
      case (op)
        1: begin m_ar = 128; m_irq = 0; m_try_tx(); end
        2: begin m_bm = 0; m_ar = 0; m_rx.delete(); end
        3: if (m_rx.size()) void'(m_rx.pop_front());
        4: if (m_rx.size()) begin m_release(m_rx[0]); void'(m_rx.pop_front()); end
        5: m_release(cur_pkt);
        default: ;
      endcase
    end
    if (fl_tx) begin
      m_tx.delete(); m_dn.delete();
    end else begin
      if (e_start) void'(m_tx.pop_front());
      if (cv && op == 6 && m_tx.size() < 4) m_tx.push_back(cur_pkt);
      if (done_ack && m_dn.size()) void'(m_dn.pop_front());
      if (done_ok && !auto_release && m_dn.size() < 4) m_dn.push_back(m_cur);
    end
    e_acc = rx_req && rx_enable && !rx_soft_rst && !fl_all && m_bm != 15 &&
            m_rx.size() < 4;
    if (e_acc) begin
      e_buf = lowest_free(m_bm);
      m_bm  = m_bm | (1 << e_buf);
      m_rx.push_back(e_buf);
    end
    if (fl_tx) m_busy = 0;
    else if (e_start) begin m_busy = 1; m_cur = e_pkt; end
    else if (done_ok) m_busy = 0;
    chk("R10", "tx_start", tx_start, e_start);
    if (e_start) chk("R10", "tx_pkt", tx_pkt, e_pkt);
    chk("R6", "rx_accept", rx_accept, e_acc);
    if (e_acc) chk("R6", "rx_buf", rx_buf, e_buf);
    if (tx_start) n_starts++;
  endtask

  task automatic cyc();
    #2;
    compare_and_step();
    @(negedge clk);
  endtask

  task automatic cmd(int op, int pkt);
    cmd_valid = 1;
    cmd_byte  = {op[2:0], 5'b10101};
    cur_pkt   = pkt[1:0];
    cyc();
    cmd_valid = 0;
    cmd_byte  = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // reset state
    chk("R4", "reset alloc_result", alloc_result, 0);
    chk("R5", "reset rx_head", rx_head, 128);
    chk("R13", "reset total", total_count, 4);

    // R1: four allocations take buffers 0,1,2,3 in order
    for (int i = 0; i < 4; i++) begin
      cmd(1, 0);
      chk("R1", "alloc order", alloc_result, i);
    end
    // R2: fifth allocation fails
    cmd(1, 0);
    chk("R2", "full result", alloc_result, 128);
    chk("R2", "full irq", alloc_irq, 0);
    // R3: release of buffer 2 retries the pending allocation
    cmd(5, 2);
    chk("R3", "retry result", alloc_result, 2);
    chk("R3", "retry irq", alloc_irq, 1);
    chk("R3", "retry count", alloc_count, 4);

    // R9: five enqueues with transmitter off, the fifth ignored
    for (int i = 0; i < 5; i++) cmd(6, i % 4);
    chk("R10", "no start while disabled", tx_start, 0);
    tx_enable = 1;
    n_starts = 0;
    for (int i = 0; i < 10; i++) begin
      tx_done = i[0];
      cyc();
    end
    tx_done = 0;
    chk("R9", "starts after overfill", n_starts, 4);
    chk("R11", "done head order", done_head, 0);
    done_ack = 1; cyc(); done_ack = 0;
    chk("R11", "done after ack", done_head, 1);
    // R12: flush of transmit and completion queues
    cmd(7, 0);
    chk("R12", "flushed done head", done_head, 128);
    chk("R12", "flushed txq", txq_empty, 1);
    chk("R12", "bitmap kept", alloc_count, 4);
    // R4: allocator reset
    cmd(2, 0);
    chk("R4", "cleared count", alloc_count, 0);
    chk("R4", "cleared result", alloc_result, 0);

    // R6: receive burst fills all buffers
    rx_enable = 1; rx_req = 1;
    repeat (5) cyc();
    rx_req = 0;
    chk("R6", "rx head", rx_head, 0);
    chk("R6", "rx count", alloc_count, 4);
    chk("R6", "rx not ready", rx_ready, 0);
    // R8: pop keeps buffer, pop-and-free releases it
    cmd(3, 0);
    chk("R8", "pop head", rx_head, 1);
    chk("R8", "pop keeps", alloc_count, 4);
    cmd(4, 0);
    chk("R8", "free head", rx_head, 2);
    chk("R8", "free count", alloc_count, 3);
    // R7: requests ignored when disabled or in soft reset
    rx_enable = 0; rx_req = 1; cyc(); rx_req = 0;
    chk("R7", "disabled count", alloc_count, 3);
    chk("R7", "disabled ready", rx_ready, 1);
    rx_enable = 1; rx_soft_rst = 1; rx_req = 1; cyc(); rx_req = 0; rx_soft_rst = 0;
    chk("R7", "soft reset count", alloc_count, 3);

    // R11: automatic release after transmit
    cmd(2, 0);
    auto_release = 1;
    cmd(1, 0);
    cmd(6, 0);
    cyc();
    tx_done = 1; cyc(); tx_done = 0;
    chk("R11", "auto release count", alloc_count, 0);
    chk("R11", "auto release no done", done_head, 128);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom;
      cmd_valid = (r % 4) == 0;
      cmd_byte  = {((r >> 3) % 9 == 0) ? 3'd2 : 3'((r >> 6) % 8), 5'((r >> 9))};
      if (cmd_byte[7:5] == 3'd2 && ((r >> 14) % 3) != 0) cmd_byte[7:5] = 3'd1;
      cur_pkt   = 2'(r >> 16);
      rx_req    = ((r >> 18) % 3) == 0;
      tx_done   = ((r >> 20) % 3) == 0;
      done_ack  = ((r >> 22) % 5) == 0;
      if ((r >> 25) % 50 == 0) tx_enable = ~tx_enable;
      if ((r >> 26) % 60 == 0) auto_release = ~auto_release;
      if ((r >> 27) % 70 == 0) rx_enable = ~rx_enable;
      rx_soft_rst = ((r >> 28) % 40) == 0;
      cyc();
    end
    summary();
  end

endmodule